// File: doc/BRIEF.md
# Serial Flash Request Sequencer

This block sits on the host side of a serial NOR flash. It turns one request into the whole run of chip-select-framed commands that the flash needs. There are four request kinds: plain read, fast read, page program and sector erase. A request carries a kind, a 24-bit address and a byte count. Program data arrives on a byte stream with a valid/ready pair. Read data leaves as a byte with a one-cycle valid strobe.

On the serial side the block drives the clock, the data-out line and an active-low select, and samples the data-in line. It works in SPI mode 0, and a run-time divider sets the serial clock rate. Program and erase requests are always preceded by a write-enable frame. After the program or erase frame, the block reads the status register repeatedly until the busy bit clears. The outcome is reported with a single done pulse and a result code: 0 means success, 1 means the length was rejected, 2 means the status polling timed out.

Top module: `spiseq_top`

## Requirements
- R1: While reset is high and after it drops, `cs_n` is 1, `sclk` is 0, `req_ready` is 1 and `done` is 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the done pulse, and any request offered during that time is dropped without starting a frame.
- R3: `cs_n` is 0 for the whole of each command and returns to 1 for at least `clk_div`+1 cycles between two commands. `sclk` is 0 whenever `cs_n` is 1.
- R4: `sclk` idles low, and each of its high and low phases lasts `clk_div`+1 clock cycles. Bytes go out MSB first, `mosi` changes only while `sclk` is low, and `miso` is sampled as `sclk` rises.
- R5: Kind 0 sends opcode 0x03 and then three address bytes, MSB first. Kind 1 sends 0x0B, the three address bytes and one dummy byte. Both then capture `req_len` bytes and present each one on `rd_data` with a one-cycle `rd_valid`.
- R6: Kind 2 first sends a frame holding only 0x06. It then sends 0x02, the address and `req_len` bytes, each taken from the write stream in a cycle where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 1 only inside that frame.
- R7: Kind 3 sends a frame holding only 0x06, then 0x20 with the address whose low 12 bits are cleared, which selects the enclosing 4 KB sector.
- R8: After a kind 2 or 3 command, the block repeats frames of 0x05 plus one read byte until bit 0 of the returned byte is 0. Only then does it pulse `done` with result 0.
- R9: A kind 2 request with `req_len` above 256 ends with `done` and result 1, and produces no chip-select activity.
- R10: If `POLL_MAX` status reads in a row all return bit 0 set, the request ends with result 2 and no further poll is made.
- R11: A status read that returns bit 0 clear on exactly the `POLL_MAX`-th poll ends with result 0, not 2.
- R12: `done` is a one-cycle pulse, and `req_ready` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Serial clock half-period minus one, in clock cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 read, 1 fast read, 2 page program, 3 sector erase |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Byte count for read or program |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Program data byte taken this cycle when valid |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | Request finished |
| result | output | 2 | 0 ok, 1 length error, 2 poll timeout |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 1 | Active-low flash select |

## Verification
Two decisions can land on the same status byte: the busy bit clearing and the poll limit running out. The bench provokes this by having its flash model report busy for exactly `POLL_MAX`-1 reads, so the last allowed poll is the first one that reads idle. The scoreboard then requires result 0 and exactly `POLL_MAX` status frames. A second run with a flash that never clears busy must give result 2 after the same number of frames.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_FAST  = 2'd1,
        K_PROG  = 2'd2,
        K_ERASE = 2'd3
    } kind_t;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_LEN     = 2'd1,
        RES_TIMEOUT = 2'd2
    } res_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_HDR,
        ST_DATA,
        ST_GAP,
        ST_POLL
    } st_t;

    typedef struct packed {
        kind_t       kind;
        logic [23:0] addr;
    } req_t;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_ERASE = 8'h20;
    localparam logic [7:0] OP_STAT  = 8'h05;

    localparam int PAGE_MAX    = 256;
    localparam int SECTOR_BITS = 12;

    function automatic logic [7:0] opcode_of(kind_t k);
        case (k)
            K_READ:  return OP_READ;
            K_FAST:  return OP_FAST;
            K_PROG:  return OP_PROG;
            default: return OP_ERASE;
        endcase
    endfunction

    // index of the final header byte: fast read adds one dummy byte
    function automatic logic [2:0] hdr_last(kind_t k);
        return (k == K_FAST) ? 3'd4 : 3'd3;
    endfunction

    function automatic logic [7:0] hdr_byte(req_t r, logic [2:0] idx);
        case (idx)
            3'd0:    return opcode_of(r.kind);
            3'd1:    return r.addr[23:16];
            3'd2:    return r.addr[15:8];
            3'd3:    return r.addr[7:0];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spiseq_tick.sv
module spiseq_tick #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)      cnt <= '0;
        else if (cnt == div) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == div) && !clr;
endmodule

// File: rtl/spiseq_byte.sv
module spiseq_byte #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [7:0]       tx,
    input  logic             miso,
    output logic             done,
    output logic [7:0]       rx,
    output logic             sclk,
    output logic             mosi
);
    logic       busy;
    logic       tick;
    logic [7:0] sr;
    logic [2:0] bitc;

    spiseq_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (!busy),
        .div  (div),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sclk <= 1'b0;
            sr   <= '0;
            rx   <= '0;
            bitc <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                sr   <= tx;
                bitc <= '0;
                sclk <= 1'b0;
            end else if (busy && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitc == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitc <= bitc + 3'd1;
                        sr   <= {sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi = sr[7];
endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
    import spiseq_pkg::*;
#(
    parameter int DIV_W    = 4,
    parameter int LEN_W    = 12,
    parameter int POLL_MAX = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic [1:0]       result,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);
    localparam logic [LEN_W-1:0]  PAGE_LEN  = LEN_W'(PAGE_MAX);

    st_t              st, after;
    logic             fin_q;
    res_t             fin_res, res_q;
    req_t             req;
    logic [LEN_W-1:0] len, cnt;
    logic [2:0]       idx;
    logic [POLL_W-1:0] polls;
    logic             inflight, eng_start, eng_done;
    logic [7:0]       eng_tx, eng_rx;
    logic [DIV_W-1:0] gap_cnt;
    kind_t            in_kind;

    assign in_kind = kind_t'(req_kind);

    spiseq_byte #(.DIV_W(DIV_W)) u_byte (
        .clk   (clk),
        .rst   (rst),
        .div   (clk_div),
        .start (eng_start),
        .tx    (eng_tx),
        .miso  (miso),
        .done  (eng_done),
        .rx    (eng_rx),
        .sclk  (sclk),
        .mosi  (mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            after     <= ST_IDLE;
            fin_q     <= 1'b0;
            fin_res   <= RES_OK;
            res_q     <= RES_OK;
            req       <= '0;
            len       <= '0;
            cnt       <= '0;
            idx       <= '0;
            polls     <= '0;
            inflight  <= 1'b0;
            eng_start <= 1'b0;
            eng_tx    <= '0;
            gap_cnt   <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            done      <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            rd_valid  <= 1'b0;
            done      <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    req.kind <= in_kind;
                    req.addr <= (in_kind == K_ERASE) ?
                                {req_addr[23:SECTOR_BITS], {SECTOR_BITS{1'b0}}} : req_addr;
                    len   <= req_len;
                    cnt   <= '0;
                    idx   <= '0;
                    polls <= '0;
                    if (in_kind == K_PROG && req_len > PAGE_LEN) begin
                        done  <= 1'b1;
                        res_q <= RES_LEN;
                    end else if (in_kind == K_PROG || in_kind == K_ERASE) begin
                        st <= ST_WREN;
                    end else begin
                        st <= ST_HDR;
                    end
                end
                ST_WREN: if (eng_done) begin
                    inflight <= 1'b0;
                    st <= ST_GAP; gap_cnt <= clk_div; after <= ST_HDR; fin_q <= 1'b0;
                end else if (!inflight) begin
                    eng_start <= 1'b1; eng_tx <= OP_WREN; inflight <= 1'b1;
                end
                ST_HDR: if (eng_done) begin
                    inflight <= 1'b0;
                    if (idx != hdr_last(req.kind)) begin
                        idx <= idx + 3'd1;
                    end else if (req.kind != K_ERASE && len != '0) begin
                        st <= ST_DATA;
                    end else begin
                        st <= ST_GAP; gap_cnt <= clk_div; after <= ST_POLL;
                        fin_q <= (req.kind == K_READ || req.kind == K_FAST);
                        fin_res <= RES_OK;
                    end
                end else if (!inflight) begin
                    eng_start <= 1'b1; eng_tx <= hdr_byte(req, idx); inflight <= 1'b1;
                end
                ST_DATA: if (eng_done) begin
                    inflight <= 1'b0;
                    cnt <= cnt + 1'b1;
                    if (req.kind != K_PROG) begin
                        rd_valid <= 1'b1;
                        rd_data  <= eng_rx;
                    end
                    if (cnt == len - 1'b1) begin
                        st <= ST_GAP; gap_cnt <= clk_div; after <= ST_POLL;
                        fin_q <= (req.kind != K_PROG); fin_res <= RES_OK;
                    end
                end else if (!inflight) begin
                    if (req.kind != K_PROG) begin
                        eng_start <= 1'b1; eng_tx <= 8'h00; inflight <= 1'b1;
                    end else if (wr_valid) begin
                        eng_start <= 1'b1; eng_tx <= wr_data; inflight <= 1'b1;
                    end
                end
                ST_POLL: if (eng_done) begin
                    inflight <= 1'b0;
                    if (idx == 3'd0) begin
                        idx <= 3'd1;
                    end else begin
                        st <= ST_GAP; gap_cnt <= clk_div; after <= ST_POLL;
                        if (!eng_rx[0]) begin
                            fin_q <= 1'b1; fin_res <= RES_OK;
                        end else if (polls == POLL_LAST) begin
                            fin_q <= 1'b1; fin_res <= RES_TIMEOUT;
                        end else begin
                            fin_q <= 1'b0; polls <= polls + 1'b1;
                        end
                    end
                end else if (!inflight) begin
                    eng_start <= 1'b1; inflight <= 1'b1;
                    eng_tx <= (idx == 3'd0) ? OP_STAT : 8'h00;
                end
                ST_GAP: if (gap_cnt == '0) begin
                    idx <= '0;
                    if (fin_q) begin
                        done  <= 1'b1;
                        res_q <= fin_res;
                        st    <= ST_IDLE;
                    end else begin
                        st <= after;
                    end
                end else begin
                    gap_cnt <= gap_cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign wr_ready  = (st == ST_DATA) && (req.kind == K_PROG) && !inflight;
    assign cs_n      = !(st == ST_WREN || st == ST_HDR || st == ST_DATA || st == ST_POLL);
    assign result    = res_q;
endmodule

// File: rtl/spiseq_chk.sv
module spiseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       done,
    input logic       wr_ready
);
    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    // R6
    wr_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !cs_n);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind == 2'd0) |=> !req_ready);
endmodule

bind spiseq_top spiseq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .done      (done),
    .wr_ready  (wr_ready)
);

// File: tb/spiseq_top_test.sv
module spiseq_top_test;
    localparam int POLLS = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  clk_div = 4'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [23:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        done;
    logic [1:0]  result;
    logic        sclk, mosi, cs_n;
    logic        miso = 1'b0;

    spiseq_top #(.DIV_W(4), .LEN_W(12), .POLL_MAX(POLLS)) uut (
        .clk(clk), .rst(rst), .clk_div(clk_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .result(result),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] mem [int];
    logic [7:0] fr [$];
    logic [7:0] ops [$];
    int   busy_left = 0, busy_set = 3, bitc = 0;
    bit   stuck = 0, wel = 0, ld = 0;
    logic [7:0] rxs, nxt, txs;
    logic [23:0] erase_addr = '0;

    function automatic logic [7:0] rdm(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    always @(negedge cs_n) begin
        bitc = 0;
        fr.delete();
        ld = 0;
    end

    always @(posedge sclk) if (!cs_n) begin
        rxs = {rxs[6:0], mosi};
        bitc++;
        if (bitc == 8) begin
            int n, base;
            bitc = 0;
            fr.push_back(rxs);
            n = fr.size();
            nxt = 8'h00;
            if (fr[0] == 8'h05 && n == 1)
                nxt = {6'b0, wel, (stuck || busy_left > 0)};
            else if (fr[0] == 8'h03 && n >= 4) begin
                base = {fr[1], fr[2], fr[3]};
                nxt = rdm(base + n - 4);
            end else if (fr[0] == 8'h0B && n >= 5) begin
                base = {fr[1], fr[2], fr[3]};
                nxt = rdm(base + n - 5);
            end
            ld = 1;
        end
    end

    always @(negedge sclk) if (!cs_n) begin
        if (ld) begin
            miso = nxt[7];
            txs = {nxt[6:0], 1'b0};
            ld = 0;
        end else begin
            miso = txs[7];
            txs = {txs[6:0], 1'b0};
        end
    end

    always @(posedge cs_n) if (fr.size() > 0) begin
        int a;
        ops.push_back(fr[0]);
        case (fr[0])
            8'h06: wel = 1;
            8'h02: if (wel) begin
                for (int i = 4; i < fr.size(); i++) begin
                    a = {fr[1], fr[2], 8'(int'(fr[3]) + i - 4)};
                    mem[a] = rdm(a) & fr[i];
                end
                busy_left = busy_set;
                wel = 0;
            end
            8'h20: if (wel) begin
                erase_addr = {fr[1], fr[2], fr[3]};
                a = {fr[1], fr[2], fr[3]} & 32'hFFF000;
                for (int k = 0; k < 4096; k++) if (mem.exists(a + k)) mem.delete(a + k);
                busy_left = busy_set;
                wel = 0;
            end
            8'h05: if (busy_left > 0) busy_left--;
            default: ;
        endcase
    end

    // ---------------- write stream ----------------
    logic [7:0] wq [$];
    always @(posedge clk) if (wr_valid && wr_ready) void'(wq.pop_front());
    always @(negedge clk) begin
        wr_valid = (wq.size() > 0);
        wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
    end

    // ---------------- scoreboard ----------------
    logic [7:0] exp_rd [$];
    logic [1:0] exp_res [$];
    bit prev_done = 0;

    always @(negedge clk) if (!rst) begin
        if (rd_valid) begin
            if (exp_rd.size() == 0) chk(0, "R5 unexpected read byte", rd_data, 0);
            else begin
                logic [7:0] e;
                e = exp_rd.pop_front();
                chk(rd_data == e, "R5 read byte", rd_data, e);
            end
        end
        if (done) begin
            logic [1:0] e;
            e = (exp_res.size() > 0) ? exp_res.pop_front() : 2'd3;
            chk(result == e, "R8 result code", result, e);
            chk(req_ready, "R12 ready with done", req_ready, 1);
            chk(!prev_done, "R12 single-cycle done", prev_done, 0);
            done_cnt++;
        end
        prev_done = done;
    end

    // serial timing monitors
    int hi_run = 0, last_hi = 0, cs_run = 0, min_gap = 1000;
    always @(negedge clk) begin
        if (sclk) hi_run++;
        else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
        if (cs_n === 1'b1) cs_run++;
        else begin
            if (cs_run > 0 && cs_run < min_gap) min_gap = cs_run;
            cs_run = 0;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input logic [1:0] k, input logic [23:0] a, input logic [11:0] n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_kind = k; req_addr = a; req_len = n;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic run(input logic [1:0] k, input logic [23:0] a, input logic [11:0] n);
        int d0;
        d0 = done_cnt;
        issue(k, a, n);
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_read(input int a, input int n);
        for (int i = 0; i < n; i++) exp_rd.push_back(rdm(a + i));
        exp_res.push_back(2'd0);
    endtask

    task automatic chk_ops(input logic [7:0] e[$], input string tag);
        bit ok;
        ok = (ops.size() == e.size());
        for (int i = 0; i < e.size() && ok; i++) ok = (ops[i] == e[i]);
        chk(ok, tag, ops.size() > 0 ? ops[ops.size()-1] : 0, e.size() > 0 ? e[e.size()-1] : 0);
        if (!ok) $display("  frames seen=%0d wanted=%0d", ops.size(), e.size());
    endtask

    function automatic int count_op(logic [7:0] op);
        int c = 0;
        foreach (ops[i]) if (ops[i] == op) c++;
        return c;
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) mem[32'h10 + i] = 8'hA0 + 8'(i);
        mem[32'h0FFF] = 8'h5A; mem[32'h1000] = 8'h11;
        mem[32'h1FFF] = 8'h22; mem[32'h2000] = 8'h77;

        repeat (5) @(negedge clk);
        chk(cs_n == 1 && sclk == 0 && req_ready == 1 && done == 0, "R1 reset outputs",
            {cs_n, sclk, req_ready, done}, 4'b1010);
        rst = 0;
        @(negedge clk);
        chk(cs_n == 1 && req_ready == 1, "R1 after reset", {cs_n, req_ready}, 2'b11);

        // R5 plain read, divider 2
        clk_div = 4'd2; ops.delete();
        expect_read(32'h10, 5);
        run(2'd0, 24'h000010, 12'd5);
        chk_ops('{8'h03}, "R5 plain read frame");
        chk(last_hi == 3, "R4 high phase div=2", last_hi, 3);

        // R5 fast read, divider 0
        clk_div = 4'd0; ops.delete();
        expect_read(32'h14, 4);
        run(2'd1, 24'h000014, 12'd4);
        chk_ops('{8'h0B}, "R5 fast read frame");
        chk(last_hi == 1, "R4 high phase div=0", last_hi, 1);
        chk(exp_rd.size() == 0, "R5 all bytes delivered", exp_rd.size(), 0);

        // R6 / R8 / R2 / R3 program
        clk_div = 4'd1; ops.delete(); busy_set = 3; min_gap = 1000;
        for (int i = 0; i < 8; i++) wq.push_back(8'h30 + 8'(i * 3));
        exp_res.push_back(2'd0);
        begin
            int d0;
            d0 = done_cnt;
            issue(2'd2, 24'h000200, 12'd8);
            repeat (20) @(negedge clk);
            chk(req_ready == 0, "R2 ready low while busy", req_ready, 0);
            req_valid = 1; req_kind = 2'd0; req_addr = 24'h10; req_len = 12'd1;
            repeat (3) @(negedge clk);
            req_valid = 0;
            while (done_cnt == d0) @(negedge clk);
            repeat (3) @(negedge clk);
        end
        chk_ops('{8'h06, 8'h02, 8'h05, 8'h05, 8'h05, 8'h05}, "R6 R8 R2 program frames");
        chk(wq.size() == 0, "R6 stream consumed", wq.size(), 0);
        chk(min_gap >= 2, "R3 deselect gap", min_gap, 2);
        ops.delete();
        expect_read(32'h200, 8);
        run(2'd0, 24'h000200, 12'd8);
        chk(mem[32'h207] == 8'h45, "R6 programmed data", mem[32'h207], 8'h45);

        // R7 erase
        ops.delete(); busy_set = 2;
        exp_res.push_back(2'd0);
        run(2'd3, 24'h001234, 12'd0);
        chk_ops('{8'h06, 8'h20, 8'h05, 8'h05, 8'h05}, "R7 erase frames");
        chk(erase_addr == 24'h001000, "R7 aligned address", erase_addr, 24'h001000);
        exp_rd.push_back(8'h5A); exp_rd.push_back(8'hFF); exp_res.push_back(2'd0);
        run(2'd0, 24'h000FFF, 12'd2);
        exp_rd.push_back(8'hFF); exp_rd.push_back(8'h77); exp_res.push_back(2'd0);
        run(2'd0, 24'h001FFF, 12'd2);

        // R9 oversize program
        ops.delete(); min_gap = 1000;
        exp_res.push_back(2'd1);
        run(2'd2, 24'h000300, 12'd300);
        chk(ops.size() == 0, "R9 no frames on length error", ops.size(), 0);

        // R10 timeout
        ops.delete(); stuck = 1;
        exp_res.push_back(2'd2);
        run(2'd3, 24'h003000, 12'd0);
        chk(count_op(8'h05) == POLLS, "R10 poll count at timeout", count_op(8'h05), POLLS);
        stuck = 0; busy_left = 0;

        // R11 busy clears on the last allowed poll
        ops.delete(); busy_set = POLLS - 1;
        wq.push_back(8'h0F);
        exp_res.push_back(2'd0);
        run(2'd2, 24'h000300, 12'd1);
        chk(count_op(8'h05) == POLLS, "R11 poll count at limit", count_op(8'h05), POLLS);
        chk(exp_res.size() == 0, "R11 results consumed", exp_res.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule